// File: doc/BRIEF.md
# Paged Descriptor Ring Address Generator

This block turns the free-running pointers of three circular descriptor rings into physical descriptor addresses. The three rings are a request ring that the host fills, a completion ring that the device fills, and a message ring that the device fills. Each ring occupies a set of fixed-size pages that need not be contiguous. A small page table per ring holds the frame number of each page. A pointer is masked to the ring size and then split into a page-table index and a slot within that page. The descriptor address is the page base plus the slot times the descriptor size.

Software-facing logic loads the page tables through a write port and then issues a setup strobe. That strobe fixes the ring sizes, clears the local pointers and produces the write-back values for the shared ring-state area. Pop strobes return the next descriptor address. Flush strobes produce the index that must be published to ring state. The caller reads the request producer index and the message indices from ring state and drives them in. The caller also performs every memory access itself.

Top module: `ring_addr_gen`

## Requirements
- R1: On a setup strobe each ring's entry count is its page count times the entries per page (4096 divided by the descriptor size). The published log2 value k is the bit length of (entries−1) as a 32-bit unsigned value, and the wrap mask becomes 2^k−1.
- R2: A request pop returns, one cycle later, base + slot×128 with valid high. The slot is (consumed & mask) mod 32. The base is the table entry at index (consumed & mask) / 32, shifted left by 12.
- R3: A completion pop is always granted, with no fullness check. It returns base + slot×32 using 128 entries per page, and then increments the filled pointer.
- R4: A message pop is always granted. It returns base + slot×128 using 32 entries per page, and then increments the message pointer.
- R5: A request pop is granted only when the request producer index differs from the local consumed pointer. The output `reqEmpty` shows equality combinationally. A refused pop gives valid low, address 0 and no pointer change. Every pointer increments without masking.
- R6: `msgHasRoom` is high exactly when (msgProdIdx − msgConsIdx) < (message mask + 1), with all terms taken as 32-bit unsigned values that wrap.
- R7: The data-ring setup clears the consumed and completion pointers and captures the ring-state frame, so that `ringStateAddr` equals that frame shifted left by 12. For one cycle it sets write-back strobes 0 to 5, which are in order: request producer, request consumer, request log2, completion producer, completion consumer, completion log2. The producer and consumer fields are written as zero.
- R8: The message setup clears the message pointer and sets strobes 6 to 8 for one cycle. Those strobes are message producer, message consumer and message log2. The producer and consumer fields are zero.
- R9: Flushes each set one strobe for one cycle. A request flush sets bit 1 and carries the consumed pointer in `wbReqCons`. A completion flush sets bit 3 with `wbCmpProd`. A message flush sets bit 6 with `wbMsgProd`. A pop in the same cycle is included in the published value.
- R10: Cleanup, and reset, zero all masks, pointers, page-table entries and the ring-state frame.
- R11: Cleanup overrides everything in the same cycle, including page-table writes. Any setup strobe suppresses all pops and flushes of that cycle. A pop reads the page table as it stood before a write made in the same cycle.
- R12: A page-table write with ring code 0 (request), 1 (completion) or 2 (message) stores the frame at the given index. Code 3 and indices beyond a table's depth are ignored. A page index past the table depth yields a base of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cleanup | input | 1 | Zero all ring state |
| setupData | input | 1 | Configure request and completion rings |
| setupMsg | input | 1 | Configure message ring |
| cfgReqPages | input | 6 | Request ring page count |
| cfgCmpPages | input | 6 | Completion ring page count |
| cfgMsgPages | input | 5 | Message ring page count |
| cfgStatePpn | input | ADDR_W−PAGE_SHIFT | Ring-state page frame |
| ptWrEn | input | 1 | Page-table write enable |
| ptWrRing | input | 2 | Target ring code |
| ptWrIdx | input | log2(DATA_PAGES) | Page-table index |
| ptWrPpn | input | ADDR_W−PAGE_SHIFT | Page frame to store |
| reqProdIdx | input | 32 | Request producer index from ring state |
| msgProdIdx | input | 32 | Message producer index from ring state |
| msgConsIdx | input | 32 | Message consumer index from ring state |
| popReq | input | 1 | Take next request descriptor |
| popCmp | input | 1 | Take next completion slot |
| popMsg | input | 1 | Take next message slot |
| flushReq | input | 1 | Publish request consumer index |
| flushCmp | input | 1 | Publish completion producer index |
| flushMsg | input | 1 | Publish message producer index |
| reqEmpty | output | 1 | Producer index equals consumed pointer |
| msgHasRoom | output | 1 | Message ring has a free slot |
| reqAddr | output | ADDR_W | Request descriptor address |
| reqValid | output | 1 | Request pop granted |
| cmpAddr | output | ADDR_W | Completion descriptor address |
| cmpValid | output | 1 | Completion pop done |
| msgAddr | output | ADDR_W | Message descriptor address |
| msgValid | output | 1 | Message pop done |
| ringStateAddr | output | ADDR_W | Byte address of ring-state page |
| wbStrb | output | 9 | Ring-state field write strobes |
| wbReqCons | output | 32 | Request consumer index value |
| wbCmpProd | output | 32 | Completion producer index value |
| wbMsgProd | output | 32 | Message producer index value |
| wbReqLog2 | output | 6 | Request log2 entry count |
| wbCmpLog2 | output | 6 | Completion log2 entry count |
| wbMsgLog2 | output | 6 | Message log2 entry count |

## Verification
The hardest case to reach is a page index that runs past the end of a page table. That only happens when a page count that is not a power of two rounds the mask up beyond the table, and the pointer then walks thousands of entries. The stimulus configures a 33-page completion ring, which gives a mask of 8191. It then pops well over 4096 completion slots, so the pointer crosses into the unbacked region and then wraps. Random cycles around this mix request producer indices that equal or exceed the consumed pointer. They also cover message index pairs near the wrap boundary, page writes made in the same cycle as pops, and occasional setup or cleanup strobes that collide with pops.

// File: rtl/ring_gen_pkg.sv
package ring_gen_pkg;

  localparam int PTR_W = 32;
  localparam int LOG_W = 6;
  localparam int WB_N  = 9;

  // write-back field positions
  localparam int WB_REQ_PROD = 0;
  localparam int WB_REQ_CONS = 1;
  localparam int WB_REQ_LOG2 = 2;
  localparam int WB_CMP_PROD = 3;
  localparam int WB_CMP_CONS = 4;
  localparam int WB_CMP_LOG2 = 5;
  localparam int WB_MSG_PROD = 6;
  localparam int WB_MSG_CONS = 7;
  localparam int WB_MSG_LOG2 = 8;

  typedef struct packed {
    logic clr;
    logic ldData;
    logic ldMsg;
    logic popR;
    logic popC;
    logic popM;
    logic flR;
    logic flC;
    logic flM;
    logic ptWr;
  } ring_ctl_t;

  function automatic logic [LOG_W-1:0] bit_len(input logic [PTR_W-1:0] v);
    logic [LOG_W-1:0] r;
    r = '0;
    for (int i = 0; i < PTR_W; i++) begin
      if (v[i]) r = LOG_W'(i + 1);
    end
    return r;
  endfunction

  function automatic logic [PTR_W-1:0] mask_of(input logic [LOG_W-1:0] k);
    logic [PTR_W:0] one;
    one = (PTR_W+1)'(1) << k;
    return PTR_W'(one - (PTR_W+1)'(1));
  endfunction

endpackage

// File: rtl/ring_page_map.sv
module ring_page_map #(
  parameter int DEPTH      = 32,
  parameter int EPP        = 32,
  parameter int DESC_BYTES = 128,
  parameter int PAGE_SHIFT = 12,
  parameter int ADDR_W     = 48,
  parameter int IDX_W      = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           clr,
  input  logic                           wrEn,
  input  logic [IDX_W-1:0]               wrIdx,
  input  logic [ADDR_W-PAGE_SHIFT-1:0]   wrPpn,
  input  logic [ring_gen_pkg::PTR_W-1:0] ptr,
  output logic [ADDR_W-1:0]              addr
);
  import ring_gen_pkg::*;

  localparam int PPN_W   = ADDR_W - PAGE_SHIFT;
  localparam int SLOT_W  = $clog2(EPP);
  localparam int DESC_SH = $clog2(DESC_BYTES);
  localparam int TBL_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PPN_W-1:0] tbl [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (wrEn && (int'(wrIdx) < DEPTH)) begin
      tbl[wrIdx[TBL_W-1:0]] <= wrPpn;
    end
  end

  logic [PTR_W-1:0]  pageIdx;
  logic [SLOT_W-1:0] slot;
  logic [PPN_W-1:0]  base;

  always_comb begin
    pageIdx = ptr >> SLOT_W;
    slot    = ptr[SLOT_W-1:0];
    base    = (pageIdx < PTR_W'(DEPTH)) ? tbl[pageIdx[TBL_W-1:0]] : '0;
    addr    = {base, {PAGE_SHIFT{1'b0}}} + (ADDR_W'(slot) << DESC_SH);
  end

  // R10
  tbl_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (tbl[0] == '0) && (tbl[DEPTH-1] == '0));

endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl (
  input  logic                    cleanup,
  input  logic                    setupData,
  input  logic                    setupMsg,
  input  logic                    ptWrEn,
  input  logic                    popReq,
  input  logic                    popCmp,
  input  logic                    popMsg,
  input  logic                    flushReq,
  input  logic                    flushCmp,
  input  logic                    flushMsg,
  input  logic                    reqPending,
  output ring_gen_pkg::ring_ctl_t ctl
);
  logic anySetup;
  logic runOk;

  always_comb begin
    anySetup   = setupData | setupMsg;
    runOk      = !cleanup && !anySetup;
    ctl.clr    = cleanup;
    ctl.ldData = !cleanup && setupData;
    ctl.ldMsg  = !cleanup && setupMsg;
    ctl.popR   = runOk && popReq && reqPending;
    ctl.popC   = runOk && popCmp;
    ctl.popM   = runOk && popMsg;
    ctl.flR    = runOk && flushReq;
    ctl.flC    = runOk && flushCmp;
    ctl.flM    = runOk && flushMsg;
    ctl.ptWr   = !cleanup && ptWrEn;
  end

endmodule

// File: rtl/ring_datapath.sv
module ring_datapath #(
  parameter int ADDR_W     = 48,
  parameter int PAGE_SHIFT = 12,
  parameter int DATA_PAGES = 32,
  parameter int MSG_PAGES  = 16,
  parameter int REQ_DESC   = 128,
  parameter int CMP_DESC   = 32,
  parameter int MSG_DESC   = 128
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ring_gen_pkg::ring_ctl_t       ctl,
  input  logic [5:0]                    cfgReqPages,
  input  logic [5:0]                    cfgCmpPages,
  input  logic [4:0]                    cfgMsgPages,
  input  logic [ADDR_W-PAGE_SHIFT-1:0]  cfgStatePpn,
  input  logic [1:0]                    ptWrRing,
  input  logic [$clog2(DATA_PAGES)-1:0] ptWrIdx,
  input  logic [ADDR_W-PAGE_SHIFT-1:0]  ptWrPpn,
  input  logic [31:0]                   reqProdIdx,
  input  logic [31:0]                   msgProdIdx,
  input  logic [31:0]                   msgConsIdx,
  output logic                          reqPending,
  output logic                          msgHasRoom,
  output logic [ADDR_W-1:0]             reqAddr,
  output logic                          reqValid,
  output logic [ADDR_W-1:0]             cmpAddr,
  output logic                          cmpValid,
  output logic [ADDR_W-1:0]             msgAddr,
  output logic                          msgValid,
  output logic [ADDR_W-1:0]             ringStateAddr,
  output logic [8:0]                    wbStrb,
  output logic [31:0]                   wbReqCons,
  output logic [31:0]                   wbCmpProd,
  output logic [31:0]                   wbMsgProd,
  output logic [5:0]                    wbReqLog2,
  output logic [5:0]                    wbCmpLog2,
  output logic [5:0]                    wbMsgLog2
);
  import ring_gen_pkg::*;

  localparam int PPN_W   = ADDR_W - PAGE_SHIFT;
  localparam int PAGE_B  = 1 << PAGE_SHIFT;
  localparam int REQ_EPP = PAGE_B / REQ_DESC;
  localparam int CMP_EPP = PAGE_B / CMP_DESC;
  localparam int MSG_EPP = PAGE_B / MSG_DESC;
  localparam int IDX_W   = $clog2(DATA_PAGES);

  logic [PTR_W-1:0] reqMask, cmpMask, msgMask;
  logic [PTR_W-1:0] consumed, cmpFilled, msgFilled;
  logic [PPN_W-1:0] stateBase;

  logic [PTR_W-1:0] consumedNxt, cmpFilledNxt, msgFilledNxt;
  logic [LOG_W-1:0] reqK, cmpK, msgK;
  logic [WB_N-1:0]  strbNxt;
  logic [ADDR_W-1:0] reqLook, cmpLook, msgLook;

  always_comb begin
    reqK = bit_len(PTR_W'(cfgReqPages) * PTR_W'(REQ_EPP) - PTR_W'(1));
    cmpK = bit_len(PTR_W'(cfgCmpPages) * PTR_W'(CMP_EPP) - PTR_W'(1));
    msgK = bit_len(PTR_W'(cfgMsgPages) * PTR_W'(MSG_EPP) - PTR_W'(1));
    consumedNxt  = consumed  + PTR_W'(ctl.popR);
    cmpFilledNxt = cmpFilled + PTR_W'(ctl.popC);
    msgFilledNxt = msgFilled + PTR_W'(ctl.popM);
    strbNxt = '0;
    if (ctl.ldData) strbNxt[WB_CMP_LOG2:WB_REQ_PROD] = '1;
    if (ctl.ldMsg)  strbNxt[WB_MSG_LOG2:WB_MSG_PROD] = '1;
    strbNxt[WB_REQ_CONS] = strbNxt[WB_REQ_CONS] | ctl.flR;
    strbNxt[WB_CMP_PROD] = strbNxt[WB_CMP_PROD] | ctl.flC;
    strbNxt[WB_MSG_PROD] = strbNxt[WB_MSG_PROD] | ctl.flM;
    reqPending = (reqProdIdx != consumed);
    msgHasRoom = (msgProdIdx - msgConsIdx) < (msgMask + PTR_W'(1));
    ringStateAddr = {stateBase, {PAGE_SHIFT{1'b0}}};
  end

  ring_page_map #(.DEPTH(DATA_PAGES), .EPP(REQ_EPP), .DESC_BYTES(REQ_DESC),
    .PAGE_SHIFT(PAGE_SHIFT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) reqMap_i (
    .clk(clk), .rstN(rstN), .clr(ctl.clr),
    .wrEn(ctl.ptWr && (ptWrRing == 2'd0)), .wrIdx(ptWrIdx), .wrPpn(ptWrPpn),
    .ptr(consumed & reqMask), .addr(reqLook));

  ring_page_map #(.DEPTH(DATA_PAGES), .EPP(CMP_EPP), .DESC_BYTES(CMP_DESC),
    .PAGE_SHIFT(PAGE_SHIFT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) cmpMap_i (
    .clk(clk), .rstN(rstN), .clr(ctl.clr),
    .wrEn(ctl.ptWr && (ptWrRing == 2'd1)), .wrIdx(ptWrIdx), .wrPpn(ptWrPpn),
    .ptr(cmpFilled & cmpMask), .addr(cmpLook));

  ring_page_map #(.DEPTH(MSG_PAGES), .EPP(MSG_EPP), .DESC_BYTES(MSG_DESC),
    .PAGE_SHIFT(PAGE_SHIFT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) msgMap_i (
    .clk(clk), .rstN(rstN), .clr(ctl.clr),
    .wrEn(ctl.ptWr && (ptWrRing == 2'd2)), .wrIdx(ptWrIdx), .wrPpn(ptWrPpn),
    .ptr(msgFilled & msgMask), .addr(msgLook));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqMask <= '0; cmpMask <= '0; msgMask <= '0;
      consumed <= '0; cmpFilled <= '0; msgFilled <= '0;
      stateBase <= '0;
      reqAddr <= '0; cmpAddr <= '0; msgAddr <= '0;
      reqValid <= 1'b0; cmpValid <= 1'b0; msgValid <= 1'b0;
      wbStrb <= '0;
      wbReqCons <= '0; wbCmpProd <= '0; wbMsgProd <= '0;
      wbReqLog2 <= '0; wbCmpLog2 <= '0; wbMsgLog2 <= '0;
    end else begin
      reqValid <= ctl.popR;
      cmpValid <= ctl.popC;
      msgValid <= ctl.popM;
      reqAddr  <= ctl.popR ? reqLook : '0;
      cmpAddr  <= ctl.popC ? cmpLook : '0;
      msgAddr  <= ctl.popM ? msgLook : '0;
      wbStrb   <= strbNxt;
      if (ctl.clr) begin
        reqMask <= '0; cmpMask <= '0; msgMask <= '0;
        consumed <= '0; cmpFilled <= '0; msgFilled <= '0;
        stateBase <= '0;
      end else begin
        consumed  <= consumedNxt;
        cmpFilled <= cmpFilledNxt;
        msgFilled <= msgFilledNxt;
        if (ctl.ldData) begin
          reqMask   <= mask_of(reqK);
          cmpMask   <= mask_of(cmpK);
          consumed  <= '0;
          cmpFilled <= '0;
          stateBase <= cfgStatePpn;
          wbReqCons <= '0;
          wbCmpProd <= '0;
          wbReqLog2 <= reqK;
          wbCmpLog2 <= cmpK;
        end
        if (ctl.ldMsg) begin
          msgMask   <= mask_of(msgK);
          msgFilled <= '0;
          wbMsgProd <= '0;
          wbMsgLog2 <= msgK;
        end
        if (ctl.flR) wbReqCons <= consumedNxt;
        if (ctl.flC) wbCmpProd <= cmpFilledNxt;
        if (ctl.flM) wbMsgProd <= msgFilledNxt;
      end
    end
  end

  // R5
  req_ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.popR |=> (consumed == $past(consumed) + PTR_W'(1)));

  // R7
  data_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldData |=> (consumed == '0) && (cmpFilled == '0) && (wbStrb[5:0] == 6'h3f));

  // R10
  cleanup_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clr |=> (reqMask == '0) && (cmpMask == '0) && (msgMask == '0) &&
                (msgFilled == '0) && (ringStateAddr == '0));

  // R9
  req_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flR |=> wbStrb[WB_REQ_CONS] && (wbReqCons == consumed));

  // R2
  req_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqAddr[$clog2(REQ_DESC)-1:0] == '0));

endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen #(
  parameter int ADDR_W     = 48,
  parameter int PAGE_SHIFT = 12,
  parameter int DATA_PAGES = 32,
  parameter int MSG_PAGES  = 16,
  parameter int REQ_DESC   = 128,
  parameter int CMP_DESC   = 32,
  parameter int MSG_DESC   = 128
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cleanup,
  input  logic                          setupData,
  input  logic                          setupMsg,
  input  logic [5:0]                    cfgReqPages,
  input  logic [5:0]                    cfgCmpPages,
  input  logic [4:0]                    cfgMsgPages,
  input  logic [ADDR_W-PAGE_SHIFT-1:0]  cfgStatePpn,
  input  logic                          ptWrEn,
  input  logic [1:0]                    ptWrRing,
  input  logic [$clog2(DATA_PAGES)-1:0] ptWrIdx,
  input  logic [ADDR_W-PAGE_SHIFT-1:0]  ptWrPpn,
  input  logic [31:0]                   reqProdIdx,
  input  logic [31:0]                   msgProdIdx,
  input  logic [31:0]                   msgConsIdx,
  input  logic                          popReq,
  input  logic                          popCmp,
  input  logic                          popMsg,
  input  logic                          flushReq,
  input  logic                          flushCmp,
  input  logic                          flushMsg,
  output logic                          reqEmpty,
  output logic                          msgHasRoom,
  output logic [ADDR_W-1:0]             reqAddr,
  output logic                          reqValid,
  output logic [ADDR_W-1:0]             cmpAddr,
  output logic                          cmpValid,
  output logic [ADDR_W-1:0]             msgAddr,
  output logic                          msgValid,
  output logic [ADDR_W-1:0]             ringStateAddr,
  output logic [8:0]                    wbStrb,
  output logic [31:0]                   wbReqCons,
  output logic [31:0]                   wbCmpProd,
  output logic [31:0]                   wbMsgProd,
  output logic [5:0]                    wbReqLog2,
  output logic [5:0]                    wbCmpLog2,
  output logic [5:0]                    wbMsgLog2
);
  import ring_gen_pkg::*;

  ring_ctl_t ctl;
  logic      reqPending;

  assign reqEmpty = !reqPending;

  ring_ctrl ctrl_i (
    .cleanup(cleanup), .setupData(setupData), .setupMsg(setupMsg),
    .ptWrEn(ptWrEn), .popReq(popReq), .popCmp(popCmp), .popMsg(popMsg),
    .flushReq(flushReq), .flushCmp(flushCmp), .flushMsg(flushMsg),
    .reqPending(reqPending), .ctl(ctl));

  ring_datapath #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
    .DATA_PAGES(DATA_PAGES), .MSG_PAGES(MSG_PAGES), .REQ_DESC(REQ_DESC),
    .CMP_DESC(CMP_DESC), .MSG_DESC(MSG_DESC)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cfgReqPages(cfgReqPages), .cfgCmpPages(cfgCmpPages),
    .cfgMsgPages(cfgMsgPages), .cfgStatePpn(cfgStatePpn),
    .ptWrRing(ptWrRing), .ptWrIdx(ptWrIdx), .ptWrPpn(ptWrPpn),
    .reqProdIdx(reqProdIdx), .msgProdIdx(msgProdIdx), .msgConsIdx(msgConsIdx),
    .reqPending(reqPending), .msgHasRoom(msgHasRoom),
    .reqAddr(reqAddr), .reqValid(reqValid),
    .cmpAddr(cmpAddr), .cmpValid(cmpValid),
    .msgAddr(msgAddr), .msgValid(msgValid),
    .ringStateAddr(ringStateAddr), .wbStrb(wbStrb),
    .wbReqCons(wbReqCons), .wbCmpProd(wbCmpProd), .wbMsgProd(wbMsgProd),
    .wbReqLog2(wbReqLog2), .wbCmpLog2(wbCmpLog2), .wbMsgLog2(wbMsgLog2));

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && reqEmpty) |=> (!reqValid && (reqAddr == '0)));

  // R11
  setup_blocks_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setupData || setupMsg || cleanup) |=> (!reqValid && !cmpValid && !msgValid));

endmodule

// File: tb/ring_addr_gen_tb.sv
module ring_addr_gen_tb_top;

  localparam int AW = 48;
  localparam int PW = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic cleanup = 0, setupData = 0, setupMsg = 0;
  logic [5:0] cfgReqPages = 0, cfgCmpPages = 0;
  logic [4:0] cfgMsgPages = 0;
  logic [PW-1:0] cfgStatePpn = 0;
  logic ptWrEn = 0;
  logic [1:0] ptWrRing = 0;
  logic [4:0] ptWrIdx = 0;
  logic [PW-1:0] ptWrPpn = 0;
  logic [31:0] reqProdIdx = 0, msgProdIdx = 0, msgConsIdx = 0;
  logic popReq = 0, popCmp = 0, popMsg = 0;
  logic flushReq = 0, flushCmp = 0, flushMsg = 0;

  logic reqEmpty, msgHasRoom, reqValid, cmpValid, msgValid;
  logic [AW-1:0] reqAddr, cmpAddr, msgAddr, ringStateAddr;
  logic [8:0] wbStrb;
  logic [31:0] wbReqCons, wbCmpProd, wbMsgProd;
  logic [5:0] wbReqLog2, wbCmpLog2, wbMsgLog2;

  ring_addr_gen dut_i (.*);

  int nVec = 0, nBad = 0;
  bit done = 0;

  // bench model
  logic [PW-1:0] mTbl [3][32];
  logic [31:0] mMask [3];
  logic [31:0] mPtr [3];
  logic [PW-1:0] mState;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] blen(logic [31:0] v);
    logic [5:0] r = 0;
    for (int i = 0; i < 32; i++) if (v[i]) r = 6'(i + 1);
    return r;
  endfunction

  function automatic logic [31:0] kmask(logic [5:0] k);
    return (k >= 32) ? 32'hffff_ffff : ((32'd1 << k) - 32'd1);
  endfunction

  function automatic logic [AW-1:0] expAddr(int ring, logic [31:0] ptr);
    int epp = (ring == 1) ? 128 : 32;
    int dsz = (ring == 1) ? 32 : 128;
    int dep = (ring == 2) ? 16 : 32;
    logic [31:0] m = ptr & mMask[ring];
    logic [31:0] idx = m / epp;
    logic [31:0] slot = m % epp;
    logic [AW-1:0] base = (idx < dep) ? {mTbl[ring][idx[4:0]], 12'h0} : '0;
    return base + AW'(slot) * AW'(dsz);
  endfunction

  task automatic modelClear();
    for (int r = 0; r < 3; r++) begin
      mMask[r] = 0; mPtr[r] = 0;
      for (int i = 0; i < 32; i++) mTbl[r][i] = 0;
    end
    mState = 0;
  endtask

  task automatic cycle();
    logic [AW-1:0] eR, eC, eM;
    logic vR, vC, vM;
    logic [8:0] eS;
    logic [5:0] kR, kC, kM;
    #2;
    chk("R5 reqEmpty", 64'(reqEmpty), 64'(reqProdIdx == mPtr[0]));
    chk("R6 msgHasRoom", 64'(msgHasRoom),
        64'((msgProdIdx - msgConsIdx) < (mMask[2] + 32'd1)));
    @(posedge clk);
    @(negedge clk);
    eR = 0; eC = 0; eM = 0; vR = 0; vC = 0; vM = 0; eS = 0;
    kR = blen(32'(cfgReqPages) * 32 - 1);
    kC = blen(32'(cfgCmpPages) * 128 - 1);
    kM = blen(32'(cfgMsgPages) * 32 - 1);
    if (cleanup) begin
      modelClear();
    end else begin
      if (setupData || setupMsg) begin
        if (setupData) begin
          eS[5:0] = 6'h3f;
          mMask[0] = kmask(kR); mMask[1] = kmask(kC);
          mPtr[0] = 0; mPtr[1] = 0; mState = cfgStatePpn;
        end
        if (setupMsg) begin
          eS[8:6] = 3'h7; mMask[2] = kmask(kM); mPtr[2] = 0;
        end
      end else begin
        if (popReq && (reqProdIdx != mPtr[0])) begin
          vR = 1; eR = expAddr(0, mPtr[0]); mPtr[0]++;
        end
        if (popCmp) begin vC = 1; eC = expAddr(1, mPtr[1]); mPtr[1]++; end
        if (popMsg) begin vM = 1; eM = expAddr(2, mPtr[2]); mPtr[2]++; end
        eS[1] = flushReq; eS[3] = flushCmp; eS[6] = flushMsg;
      end
      if (ptWrEn && ptWrRing != 3 && !(ptWrRing == 2 && ptWrIdx >= 16))
        mTbl[ptWrRing][ptWrIdx] = ptWrPpn;
    end
    chk("R5 reqValid", 64'(reqValid), 64'(vR));
    chk("R2 reqAddr", 64'(reqAddr), 64'(eR));
    chk("R3 cmpValid", 64'(cmpValid), 64'(vC));
    chk("R3 cmpAddr", 64'(cmpAddr), 64'(eC));
    chk("R4 msgValid", 64'(msgValid), 64'(vM));
    chk("R4 msgAddr", 64'(msgAddr), 64'(eM));
    chk("R11 wbStrb", 64'(wbStrb), 64'(eS));
    chk("R7 ringStateAddr", 64'(ringStateAddr), 64'({mState, 12'h0}));
    if (eS[1]) chk("R9 wbReqCons", 64'(wbReqCons), 64'(setupData ? 32'd0 : mPtr[0]));
    if (eS[3]) chk("R9 wbCmpProd", 64'(wbCmpProd), 64'(setupData ? 32'd0 : mPtr[1]));
    if (eS[6]) chk("R9 wbMsgProd", 64'(wbMsgProd), 64'(setupMsg ? 32'd0 : mPtr[2]));
    if (eS[2]) chk("R1 wbReqLog2", 64'(wbReqLog2), 64'(kR));
    if (eS[5]) chk("R1 wbCmpLog2", 64'(wbCmpLog2), 64'(kC));
    if (eS[8]) chk("R8 wbMsgLog2", 64'(wbMsgLog2), 64'(kM));
    cleanup = 0; setupData = 0; setupMsg = 0; ptWrEn = 0;
    popReq = 0; popCmp = 0; popMsg = 0;
    flushReq = 0; flushCmp = 0; flushMsg = 0;
  endtask

  task automatic fillTables();
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 32; i++) begin
        ptWrEn = 1; ptWrRing = 2'(r); ptWrIdx = 5'(i);
        ptWrPpn = PW'({$urandom, $urandom});
        cycle();
      end
    end
  endtask

  task automatic doSetup(logic [5:0] rp, logic [5:0] cp, logic [4:0] mp);
    cfgReqPages = rp; cfgCmpPages = cp; cfgMsgPages = mp;
    cfgStatePpn = PW'({$urandom, $urandom});
    setupData = 1; setupMsg = 1;
    cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed);
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state (R10)
    chk("R10 reset reqValid", 64'(reqValid), 0);
    chk("R10 reset wbStrb", 64'(wbStrb), 0);
    chk("R10 reset ringStateAddr", 64'(ringStateAddr), 0);
    chk("R5 reset reqEmpty", 64'(reqEmpty), 1);
    chk("R6 reset msgHasRoom", 64'(msgHasRoom), 1);

    // R12 table loading incl. ignored ring code 3
    fillTables();
    ptWrEn = 1; ptWrRing = 2'd3; ptWrIdx = 0; ptWrPpn = '1;
    cycle();

    // R1 R7 R8 power-of-two sizes
    doSetup(6'd4, 6'd2, 5'd2);
    // R1 non-power-of-two request ring
    doSetup(6'd3, 6'd1, 5'd16);

    // random mix
    for (int it = 0; it < 3000; it++) begin
      reqProdIdx = mPtr[0] + (($urandom % 3 == 0) ? 0 : ($urandom % 5));
      msgConsIdx = ($urandom % 4 == 0) ? 32'hffff_fff0 + ($urandom % 32) : $urandom;
      msgProdIdx = msgConsIdx + ($urandom % 600);
      popReq = 1'($urandom); popCmp = 1'($urandom); popMsg = 1'($urandom);
      flushReq = ($urandom % 4 == 0); flushCmp = ($urandom % 4 == 0);
      flushMsg = ($urandom % 4 == 0);
      if ($urandom % 4 == 0) begin
        ptWrEn = 1; ptWrRing = 2'($urandom); ptWrIdx = 5'($urandom);
        ptWrPpn = PW'({$urandom, $urandom});
      end
      if ($urandom % 150 == 0) begin
        setupData = 1; cfgReqPages = 6'(1 + $urandom % 33);
        cfgCmpPages = 6'(1 + $urandom % 33); cfgStatePpn = PW'($urandom);
      end
      if ($urandom % 150 == 0) begin
        setupMsg = 1; cfgMsgPages = 5'(1 + $urandom % 16);
      end
      if ($urandom % 900 == 0) cleanup = 1;
      cycle();
      if (it % 700 == 699) fillTables();
    end

    // R12 R3 completion ring past table end: 33 pages, mask 8191
    fillTables();
    doSetup(6'd2, 6'd33, 5'd1);
    for (int i = 0; i < 8300; i++) begin
      popCmp = 1; flushCmp = (i % 97 == 0);
      cycle();
    end

    // R11 cleanup wins over setup and pops
    reqProdIdx = mPtr[0] + 3;
    cleanup = 1; setupData = 1; popReq = 1; popCmp = 1; ptWrEn = 1;
    ptWrRing = 0; ptWrIdx = 0; ptWrPpn = '1;
    cycle();
    // R10 after cleanup: completion pop yields address 0
    popCmp = 1; cycle();
    reqProdIdx = 0; msgConsIdx = 32'd7; msgProdIdx = 32'd8;
    cycle();
    msgProdIdx = 32'd7; cycle();

    // R11 setup suppresses a granted request pop
    fillTables();
    doSetup(6'd1, 6'd1, 5'd1);
    reqProdIdx = 32'd5; popReq = 1; flushReq = 1; setupData = 1;
    cycle();
    popReq = 1; flushReq = 1; cycle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule